// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor core. Every clock it fetches one instruction, decodes it, runs it through the ALU and writes the result back. There is no pipelining. It runs a narrow instruction set: word load and store, branch-if-equal, immediate add, and the register-to-register operations add, subtract, AND, OR and signed set-less-than. Inside are a 32 x 32-bit register file, an immediate extender, an ALU, a next-PC unit and a main decoder. The decoder drives one control word that selects the destination register, the second ALU operand, the write-back source, the register and memory write enables, the branch and the extension mode.

Instruction memory and data memory are word arrays inside the block. Each has a synchronous write and a combinational read. While reset is held low, a load port fills either memory from outside. Once reset is released, the core runs from address zero. Two observation ports help with bring-up and checking. One reads any architectural register. The other reads any data-memory word.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC becomes 0 and every register becomes 0. After release, the instruction at byte address 0 runs on the first edge.
- R2: An instruction with opcode 0x00 writes register rd (bits 15:11) with rs (bits 25:21) op rt (bits 20:16), chosen by funct (bits 5:0): 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). The PC advances by 4.
- R3: Opcode 0x08 writes rt with rs plus the sign-extended 16-bit immediate (bits 15:0). The PC advances by 4.
- R4: Opcode 0x23 writes rt with the data word at byte address rs plus the sign-extended immediate. The two low address bits are ignored.
- R5: Opcode 0x2B writes rt into the data word at rs plus the sign-extended immediate. It changes no register.
- R6: Opcode 0x04 compares rs with rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended immediate times 4. Otherwise the next PC is PC+4. It writes nothing.
- R7: Register 0 always reads 0, and writes aimed at it have no effect.
- R8: An opcode outside {0x00, 0x04, 0x08, 0x23, 0x2B}, or an opcode 0x00 whose funct is outside the R2 list, writes no register and no memory word. The PC advances by 4.
- R9: A load-port write (`load_dmem`=1 selects data memory, 0 selects instruction memory, at word `load_addr[..:2]`) takes effect only at an edge where `rst_n` is low. At other edges it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also opens the load port |
| load_we | input | 1 | Load-port write strobe |
| load_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| load_addr | input | 32 | Load byte address (low two bits ignored) |
| load_data | input | 32 | Load word |
| pc | output | 32 | Current program counter (byte address) |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_val | output | 32 | Value of the observed register |
| dbg_mem_addr | input | 32 | Data-memory byte address to observe |
| dbg_mem_val | output | 32 | Data word at that address |

## Verification
The assertions take for granted three things about the inputs. The program is loaded while reset is low. The PC never leaves the filled part of instruction memory, so the fetched word is never unknown. The load port is quiet while the core runs, except where a test deliberately drives it. The stimulus keeps within these limits. It loads every instruction word and the data words during reset, and it ends each program in a branch to itself, so execution stays on defined words for any number of extra cycles. The one load-port write made during running is the directed test for R9. That test uses an instruction address inside the loaded region and a data address the program has already written, so the absence of an effect can be seen on the observation ports.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the single-cycle core: instruction encodings,
// ALU operation codes and the control word produced by the decoder.
// Assumes a fixed 32-bit instruction and data word.
package sc_core_pkg;

    localparam int XLEN = 32;

    // Opcode field values (bits 31:26)
    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    // Function field values (bits 5:0) for register-format operations
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    // Control points driven by the main decoder
    typedef struct packed {
        logic    dst_rd;     // 1: write rd, 0: write rt
        logic    src_imm;    // 1: second operand is extended immediate
        logic    wb_mem;     // 1: write back the data-memory word
        logic    reg_we;     // register file write enable
        logic    mem_we;     // data memory write enable
        logic    is_branch;  // branch-if-equal
        logic    ext_signed; // 1: sign extend, 0: zero extend
        alu_op_e alu_op;     // ALU operation
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// Main decoder: maps opcode and funct to the control word.
// Assumes nothing about its inputs; any unknown encoding yields a control
// word with both write enables clear and no branch (a no-op).
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    // Combinational decode of the supported instruction subset
    always_comb begin
        ctl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
                mem_we: 1'b0, is_branch: 1'b0, ext_signed: 1'b1,
                alu_op: ALU_ADD};
        case (opcode)
            OPC_REG: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_we = 1'b1;
                case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctl.src_imm = 1'b1;
                ctl.reg_we  = 1'b1;
            end
            OPC_LW: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.reg_we  = 1'b1;
            end
            OPC_SW: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.alu_op    = ALU_SUB;
            end
            default: ctl.ext_signed = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// ALU: add, subtract, AND, OR and signed set-less-than, plus a zero flag
// used by the branch compare. Purely combinational.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_op_e      op,
    output logic [W-1:0] result,
    output logic         is_zero
);

    // Operation select
    always_comb begin
        case (op)
            ALU_ADD: result = opa + opb;
            ALU_SUB: result = opa - opb;
            ALU_AND: result = opa & opb;
            ALU_OR:  result = opa | opb;
            ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: result = '0;
        endcase
    end

    assign is_zero = (result == '0);

endmodule

// File: rtl/sc_nextpc.sv
`timescale 1ns/1ps
// Next-PC unit: sequential PC+4, or PC+4 plus the extended immediate
// scaled by four when a taken branch is signalled. Combinational.
module sc_nextpc #(
    parameter int W = 32
) (
    input  logic [W-1:0] pc_cur,
    input  logic [W-1:0] imm_ext,
    input  logic         take,
    output logic [W-1:0] pc_next
);

    logic [W-1:0] pc_seq;
    logic [W-1:0] pc_tgt;

    assign pc_seq = pc_cur + W'(4);
    assign pc_tgt = pc_seq + {imm_ext[W-3:0], 2'b00};

    // Path select
    always_comb pc_next = take ? pc_tgt : pc_seq;

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// Register file: NREG words of W bits, NRD combinational read ports and
// one synchronous write port. Entry 0 is never written, so it reads zero.
// All entries clear on synchronous active-low reset.
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata
);

    logic [W-1:0] regs_q [NREG];

    // Storage update: reset clear, otherwise guarded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = regs_q[raddr[p]];
    end

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0); // R7

endmodule

// File: rtl/sc_wordmem.sv
`timescale 1ns/1ps
// Word memory: WORDS words of 32 bits, one synchronous write port and
// NRD combinational read ports, all byte-addressed with the low two bits
// and the bits above the index ignored. Contents are not reset.
// Assumes WORDS is a power of two, at least 2.
module sc_wordmem #(
    parameter int WORDS = 64,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [31:0]           waddr,
    input  logic [31:0]           wdata,
    input  logic [NRD-1:0][31:0]  raddr,
    output logic [NRD-1:0][31:0]  rdata
);

    logic [31:0] mem_q [WORDS];
    logic        unused_wbits;

    assign unused_wbits = ^{waddr[31:AW+2], waddr[1:0]};

    // Synchronous word write
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr[AW+1:2]] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic unused_rbits;
        assign unused_rbits = ^{raddr[p][31:AW+2], raddr[p][1:0]};
        assign rdata[p]     = mem_q[raddr[p][AW+1:2]];
    end

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// Single-cycle core top: fetch, decode, execute, memory and write-back all
// complete within one clock. Memories are loaded through the load port
// while rst_n is low; the core runs from address 0 once rst_n is high.
// Assumes the program keeps the PC inside the loaded instruction words.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_we,
    input  logic        load_dmem,
    input  logic [31:0] load_addr,
    input  logic [31:0] load_data,
    output logic [31:0] pc,
    input  logic [4:0]  dbg_reg_sel,
    output logic [31:0] dbg_reg_val,
    input  logic [31:0] dbg_mem_addr,
    output logic [31:0] dbg_mem_val
);

    logic [31:0] pc_q;
    logic [31:0] pc_next;
    logic [31:0] instr;
    ctrl_t       ctl;

    logic [5:0]  f_op;
    logic [4:0]  f_rs;
    logic [4:0]  f_rt;
    logic [4:0]  f_rd;
    logic [5:0]  f_fn;
    logic [15:0] f_imm;
    logic        unused_shamt;

    logic [31:0] imm_ext;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic        alu_zero;
    logic        take_br;

    logic [2:0][4:0]  rf_raddr;
    logic [2:0][31:0] rf_rdata;
    logic             rf_we;
    logic [4:0]       rf_waddr;
    logic [31:0]      rf_wdata;

    logic             im_we;
    logic [0:0][31:0] im_raddr;
    logic [0:0][31:0] im_rdata;

    logic             dm_we;
    logic [31:0]      dm_waddr;
    logic [31:0]      dm_wdata;
    logic [1:0][31:0] dm_raddr;
    logic [1:0][31:0] dm_rdata;

    // Field split
    assign f_op         = instr[31:26];
    assign f_rs         = instr[25:21];
    assign f_rt         = instr[20:16];
    assign f_rd         = instr[15:11];
    assign f_fn         = instr[5:0];
    assign f_imm        = instr[15:0];
    assign unused_shamt = ^instr[10:6];

    // Fetch
    assign im_we       = !rst_n && load_we && !load_dmem;
    assign im_raddr[0] = pc_q;
    assign instr       = im_rdata[0];

    sc_wordmem #(.WORDS(IMEM_WORDS), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (im_raddr),
        .rdata (im_rdata)
    );

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .ctl    (ctl)
    );

    // Immediate extension
    always_comb imm_ext = ctl.ext_signed ? {{16{f_imm[15]}}, f_imm}
                                         : {16'h0000, f_imm};

    // Register file: ports 0/1 for operands, port 2 for observation
    assign rf_raddr[0] = f_rs;
    assign rf_raddr[1] = f_rt;
    assign rf_raddr[2] = dbg_reg_sel;
    assign rs_val      = rf_rdata[0];
    assign rt_val      = rf_rdata[1];
    assign dbg_reg_val = rf_rdata[2];

    assign rf_we    = rst_n && ctl.reg_we;
    assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
    assign rf_wdata = ctl.wb_mem ? dm_rdata[0] : alu_y;

    sc_regfile #(.W(32), .NREG(32), .NRD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    // Execute
    assign alu_b = ctl.src_imm ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .opa     (rs_val),
        .opb     (alu_b),
        .op      (ctl.alu_op),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    // Data memory: core owns the write port while running, load port in reset
    assign dm_we       = rst_n ? ctl.mem_we : (load_we && load_dmem);
    assign dm_waddr    = rst_n ? alu_y : load_addr;
    assign dm_wdata    = rst_n ? rt_val : load_data;
    assign dm_raddr[0] = alu_y;
    assign dm_raddr[1] = dbg_mem_addr;
    assign dbg_mem_val = dm_rdata[1];

    sc_wordmem #(.WORDS(DMEM_WORDS), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    // Next PC
    assign take_br = ctl.is_branch && alu_zero;

    sc_nextpc #(.W(32)) u_npc (
        .pc_cur  (pc_q),
        .imm_ext (imm_ext),
        .take    (take_br),
        .pc_next (pc_next)
    );

    // PC register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc = pc_q;

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !take_br |=> (pc_q == $past(pc_q) + 32'd4)); // R6

    AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        take_br |=> (pc_q == $past(pc_q) + 32'd4 + ($past(imm_ext) << 2))); // R6

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !rf_we); // R5

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_op != OPC_REG) && (f_op != OPC_BEQ) && (f_op != OPC_ADDI) &&
         (f_op != OPC_LW) && (f_op != OPC_SW)) |-> (!rf_we && !dm_we)); // R8

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
// Self-checking bench: loads a program during reset, steps it one
// instruction per clock against a vector table, then runs directed tests.
module sc_core_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_we;
    logic        load_dmem;
    logic [31:0] load_addr;
    logic [31:0] load_data;
    logic [31:0] pc;
    logic [4:0]  dbg_reg_sel;
    logic [31:0] dbg_reg_val;
    logic [31:0] dbg_mem_addr;
    logic [31:0] dbg_mem_val;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    sc_core uut (
        .clk (clk), .rst_n (rst_n),
        .load_we (load_we), .load_dmem (load_dmem),
        .load_addr (load_addr), .load_data (load_data),
        .pc (pc),
        .dbg_reg_sel (dbg_reg_sel), .dbg_reg_val (dbg_reg_val),
        .dbg_mem_addr (dbg_mem_addr), .dbg_mem_val (dbg_mem_val)
    );

    localparam int NPROG = 20;
    localparam logic [31:0] PROG [NPROG] = '{
        32'h20010005, // 0  addi r1,r0,5
        32'h2002FFFD, // 1  addi r2,r0,-3
        32'h00221820, // 2  add  r3,r1,r2
        32'h00222022, // 3  sub  r4,r1,r2
        32'h00222824, // 4  and  r5,r1,r2
        32'h00223025, // 5  or   r6,r1,r2
        32'h0041382A, // 6  slt  r7,r2,r1
        32'h0022402A, // 7  slt  r8,r1,r2
        32'hAC040008, // 8  sw   r4,8(r0)
        32'h8C090008, // 9  lw   r9,8(r0)
        32'h8C0D000B, // 10 lw   r13,11(r0)
        32'h20000007, // 11 addi r0,r0,7
        32'h8C0A0004, // 12 lw   r10,4(r0)
        32'h10220005, // 13 beq  r1,r2,+5 (not taken)
        32'h10630002, // 14 beq  r3,r3,+2 (taken to 68)
        32'h200B0001, // 15 addi r11,r0,1 (skipped)
        32'h200B0001, // 16 addi r11,r0,1 (skipped)
        32'hFFFFFFFF, // 17 undefined opcode
        32'h0021603F, // 18 reg format, undefined funct
        32'h1000FFFF  // 19 beq r0,r0,-1 (self loop)
    };

    typedef struct packed {
        logic        is_mem;
        logic [31:0] idx;
        logic [31:0] val;
        logic [31:0] pc_exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'd1,  32'h00000005, 32'd4,  4'd3}, // R3
        '{1'b0, 32'd2,  32'hFFFFFFFD, 32'd8,  4'd3}, // R3 negative immediate
        '{1'b0, 32'd3,  32'h00000002, 32'd12, 4'd2}, // R2 add
        '{1'b0, 32'd4,  32'h00000008, 32'd16, 4'd2}, // R2 sub
        '{1'b0, 32'd5,  32'h00000005, 32'd20, 4'd2}, // R2 and
        '{1'b0, 32'd6,  32'hFFFFFFFD, 32'd24, 4'd2}, // R2 or
        '{1'b0, 32'd7,  32'h00000001, 32'd28, 4'd2}, // R2 slt true (signed)
        '{1'b0, 32'd8,  32'h00000000, 32'd32, 4'd2}, // R2 slt false
        '{1'b1, 32'd8,  32'h00000008, 32'd36, 4'd5}, // R5 store
        '{1'b0, 32'd9,  32'h00000008, 32'd40, 4'd4}, // R4 load
        '{1'b0, 32'd13, 32'h00000008, 32'd44, 4'd4}, // R4 low bits ignored
        '{1'b0, 32'd0,  32'h00000000, 32'd48, 4'd7}, // R7 write to r0
        '{1'b0, 32'd10, 32'hCAFEF00D, 32'd52, 4'd4}, // R4 preloaded word
        '{1'b0, 32'd1,  32'h00000005, 32'd56, 4'd6}, // R6 not taken
        '{1'b0, 32'd3,  32'h00000002, 32'd68, 4'd6}, // R6 taken forward
        '{1'b0, 32'd31, 32'h00000000, 32'd72, 4'd8}, // R8 undefined opcode
        '{1'b0, 32'd12, 32'h00000000, 32'd76, 4'd8}, // R8 undefined funct
        '{1'b0, 32'd4,  32'h00000008, 32'd76, 4'd6}, // R6 backward target
        '{1'b0, 32'd4,  32'h00000008, 32'd76, 4'd6}  // R6 loop holds
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic see_reg(input int req, input logic [4:0] r,
                           input logic [31:0] exp);
        dbg_reg_sel = r;
        #0.1;
        chk(req, $sformatf("reg %0d", r), dbg_reg_val, exp);
    endtask

    task automatic see_mem(input int req, input logic [31:0] a,
                           input logic [31:0] exp);
        dbg_mem_addr = a;
        #0.1;
        chk(req, $sformatf("mem @%0d", a), dbg_mem_val, exp);
    endtask

    initial begin
        rst_n        = 1'b0;
        load_we      = 1'b0;
        load_dmem    = 1'b0;
        load_addr    = '0;
        load_data    = '0;
        dbg_reg_sel  = '0;
        dbg_mem_addr = '0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NPROG; i++) begin
            load_we   = 1'b1;
            load_dmem = 1'b0;
            load_addr = 32'(i * 4);
            load_data = PROG[i];
            @(negedge clk);
        end
        load_dmem = 1'b1;
        load_addr = 32'd4;
        load_data = 32'hCAFEF00D;
        @(negedge clk);
        load_we = 1'b0;

        // R1 reset state
        chk(1, "pc in reset", pc, 32'd0);
        see_reg(1, 5'd1, 32'd0);
        see_mem(9, 32'd4, 32'hCAFEF00D); // R9 load during reset lands

        rst_n = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            chk(int'(VEC[v].req), $sformatf("pc step %0d", v), pc, VEC[v].pc_exp);
            if (VEC[v].is_mem) see_mem(int'(VEC[v].req), VEC[v].idx, VEC[v].val);
            else               see_reg(int'(VEC[v].req), VEC[v].idx[4:0], VEC[v].val);
        end

        // R6 skipped instructions left r11 alone
        see_reg(6, 5'd11, 32'd0);

        // R9 load port ignored while running
        load_we   = 1'b1;
        load_dmem = 1'b1;
        load_addr = 32'd8;
        load_data = 32'h00001234;
        @(negedge clk);
        load_dmem = 1'b0;
        load_addr = 32'd76;
        load_data = 32'h200E0009; // addi r14,r0,9
        @(negedge clk);
        load_we = 1'b0;
        @(negedge clk);
        see_mem(9, 32'd8, 32'h00000008);
        see_reg(9, 5'd14, 32'd0);
        chk(9, "pc after ignored load", pc, 32'd76);

        // R1 reset again clears PC and registers
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, "pc after reset", pc, 32'd0);
        see_reg(1, 5'd1, 32'd0);
        see_reg(1, 5'd10, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule